// File: doc/BRIEF.md
# SMBus Control Register Target

This block is a two-wire serial target that holds six eight-bit control registers for a differential clock fanout stage. A host reaches the registers with four transaction kinds: a single-register write, a single-register read, a counted multi-register write and a counted multi-register read. Both bus lines are sampled with the fast system clock. The data line is pulled low through an open-drain enable and is never driven high. The clock line is never held.

The command byte that follows the write address selects the access kind and the first register. If bit 7 of the command is 1, the access is single-register. If bit 7 is 0, the access is counted. Bits 6:0 give the register index. A counted write carries a count byte ahead of its data. In a counted read, the target sends the current value of the count register first and then the register contents. The register fields drive two output enables, an amplitude override with its level code, identification fields and the count value.

Top module: `smb_reg_target`

## Requirements
- R1: The target acknowledges a first byte of D6h (7-bit address 6Bh, write) or D7h (read). For any other address it leaves SDA released and changes no register.
- R2: After reset the registers hold: index 0 = 00h, 1 = 00h, 2 = C0h, 3 = 08h, 4 = 06h, 5 = D8h.
- R3: For a single-register write (command bit 7 = 1, index in bits 6:0), the first data byte is stored at the index. Further data bytes are acknowledged and discarded.
- R4: A single-register read is: write address, command, repeated START, read address. It returns the indexed register MSB first.
- R5: For a counted write (command bit 7 = 0), the first data byte is the count N. Up to N following bytes are stored at ascending indices from the command index. Bytes after the N-th are acknowledged and discarded.
- R6: A counted read returns index 4 first, then the registers at ascending indices from the command index. The host can end the read with a NACK after any byte, including the count byte.
- R7: Writes to an index of 6 or above are acknowledged and have no effect. Reads from such an index return 00h.
- R8: Register fields map to the outputs as follows. out_en_o[0] = reg2 bit 7 and out_en_o[1] = reg2 bit 6. amp_sel_o = reg5 bit 7 and amp_code_o = reg5 bits 6:4. rev_code_o = reg3 bits 7:4 and vendor_id_o = reg3 bits 3:0. byte_cnt_o = reg4.
- R9: The SDA enable changes only while the synchronised SCL is low. It is released during the host's acknowledge slot and while the target is idle.
- R10: A START seen at any point restarts address decoding. A partly received byte is then dropped, and a STOP ends the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| out_en_o | output | 2 | Clock output enables, bit n for output n |
| amp_sel_o | output | 1 | Custom amplitude select |
| amp_code_o | output | 3 | Amplitude level code, 300 mV + 100 mV per step |
| rev_code_o | output | 4 | Revision code field |
| vendor_id_o | output | 4 | Vendor identification field |
| byte_cnt_o | output | 8 | Count register value |

## Verification
The situation that is hardest to reach is a START that arrives part-way through a data byte. The bench creates it by clocking three data bits of a write to the amplitude register and then raising SDA and dropping it again while SCL is high. It then confirms that the partial byte left no trace and that a following write completes normally. Counted writes whose data length differs from their count, and counted accesses that run past the last register, come from random lengths and start indices.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int IDX_W = 7;
  localparam int IDX_OE  = 2;
  localparam int IDX_ID  = 3;
  localparam int IDX_CNT = 4;
  localparam int IDX_AMP = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } link_st_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_CMD, PH_CNT, PH_DATA
  } phase_e;

  function automatic logic [7:0] reg_reset(input int idx);
    case (idx)
      IDX_OE:  return 8'hC0;
      IDX_ID:  return 8'h08;
      IDX_CNT: return 8'h06;
      IDX_AMP: return 8'hD8;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_sync_det.sv
module smb_sync_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff[0] <= 1'b1;
          sda_ff[0] <= 1'b1;
        end else begin
          scl_ff[0] <= scl_i;
          sda_ff[0] <= sda_i;
        end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_o;
      sda_d <= sda_o;
    end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges with SCL steady high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_pkg::*;
#(
  parameter int NUM_REGS = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic [1:0]       oe_o,
  output logic             amp_sel_o,
  output logic [2:0]       amp_code_o,
  output logic [3:0]       rev_o,
  output logic [3:0]       vid_o,
  output logic [7:0]       cnt_o
);
  logic [NUM_REGS-1:0][7:0] regs_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)
        regs_q[i] <= reg_reset(i);
      else if (wr_en_i && wr_idx_i == IDX_W'(i))
        regs_q[i] <= wr_data_i;
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx_i == IDX_W'(i)) rd_data_o = regs_q[i];
  end

  assign oe_o       = {regs_q[IDX_OE][6], regs_q[IDX_OE][7]};
  assign amp_sel_o  = regs_q[IDX_AMP][7];
  assign amp_code_o = regs_q[IDX_AMP][6:4];
  assign rev_o      = regs_q[IDX_ID][7:4];
  assign vid_o      = regs_q[IDX_ID][3:0];
  assign cnt_o      = regs_q[IDX_CNT];
endmodule

// File: rtl/smb_link.sv
module smb_link
  import smb_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h6B
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       cnt_i,
  input  logic [7:0]       rd_data_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o,
  output link_st_e         state_o
);
  link_st_e         state_q;
  phase_e           phase_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       sh_q;
  logic [7:0]       left_q;
  logic [IDX_W-1:0] idx_q;
  logic             block_q, rd_mode_q, cnt_first_q, host_ack_q;
  logic [7:0]       tx_byte;

  assign tx_byte  = cnt_first_q ? cnt_i : rd_data_i;
  assign rd_idx_o = idx_q;
  assign state_o  = state_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_ADDR;
      bit_cnt_q   <= '0;
      sh_q        <= '0;
      left_q      <= '0;
      idx_q       <= '0;
      block_q     <= 1'b0;
      rd_mode_q   <= 1'b0;
      cnt_first_q <= 1'b0;
      host_ack_q  <= 1'b0;
      sda_oe_o    <= 1'b0;
      wr_en_o     <= 1'b0;
      wr_idx_o    <= '0;
      wr_data_o   <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state_q   <= ST_RX;
        phase_q   <= PH_ADDR;
        bit_cnt_q <= '0;
        sda_oe_o  <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_RX: begin
            if (scl_rise_i) begin
              sh_q      <= {sh_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              bit_cnt_q <= '0;
              state_q   <= ST_RX_ACK;
              sda_oe_o  <= 1'b1;
              unique case (phase_q)
                PH_ADDR: begin
                  if (sh_q[7:1] != ADDR7) begin
                    sda_oe_o <= 1'b0;
                    state_q  <= ST_IDLE;
                  end else begin
                    rd_mode_q   <= sh_q[0];
                    cnt_first_q <= sh_q[0] & block_q;
                    phase_q     <= PH_CMD;
                  end
                end
                PH_CMD: begin
                  idx_q   <= sh_q[IDX_W-1:0];
                  block_q <= ~sh_q[7];
                  left_q  <= 8'd1;
                  phase_q <= sh_q[7] ? PH_DATA : PH_CNT;
                end
                PH_CNT: begin
                  left_q  <= sh_q;
                  phase_q <= PH_DATA;
                end
                PH_DATA: begin
                  if (left_q != 8'd0) begin
                    wr_en_o   <= 1'b1;
                    wr_idx_o  <= idx_q;
                    wr_data_o <= sh_q;
                    idx_q     <= idx_q + 1'b1;
                    left_q    <= left_q - 8'd1;
                  end
                end
                default: ;
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall_i) begin
              if (rd_mode_q) begin
                sh_q      <= tx_byte;
                sda_oe_o  <= ~tx_byte[7];
                bit_cnt_q <= '0;
                state_q   <= ST_TX;
                if (cnt_first_q) cnt_first_q <= 1'b0;
                else             idx_q <= idx_q + 1'b1;
              end else begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (bit_cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_TX_ACK;
              end else begin
                sh_q     <= {sh_q[6:0], 1'b0};
                sda_oe_o <= ~sh_q[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) begin
              host_ack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (host_ack_q) begin
                sh_q      <= tx_byte;
                sda_oe_o  <= ~tx_byte[7];
                bit_cnt_q <= '0;
                state_q   <= ST_TX;
                if (cnt_first_q) cnt_first_q <= 1'b0;
                else             idx_q <= idx_q + 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
endmodule

// File: rtl/smb_reg_target.sv
module smb_reg_target
  import smb_pkg::*;
#(
  parameter logic [6:0] ADDR7       = 7'h6B,
  parameter int         NUM_REGS    = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [1:0] out_en_o,
  output logic       amp_sel_o,
  output logic [2:0] amp_code_o,
  output logic [3:0] rev_code_o,
  output logic [3:0] vendor_id_o,
  output logic [7:0] byte_cnt_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_s, stop_s;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;
  link_st_e         link_state;

  smb_sync_det #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_s), .stop_o(stop_s)
  );

  smb_link #(.ADDR7(ADDR7)) i_link (
    .clk_i, .rst_ni,
    .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_s), .stop_i(stop_s),
    .cnt_i(byte_cnt_o), .rd_data_i(rd_data), .rd_idx_o(rd_idx),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .sda_oe_o, .state_o(link_state)
  );

  smb_regbank #(.NUM_REGS(NUM_REGS)) i_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .oe_o(out_en_o), .amp_sel_o, .amp_code_o,
    .rev_o(rev_code_o), .vid_o(vendor_id_o), .cnt_o(byte_cnt_o)
  );
endmodule

// File: rtl/smb_reg_target_chk.sv
module smb_reg_target_chk
  import smb_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       start_s,
  input logic       sda_oe,
  input link_st_e   state,
  input logic [7:0] byte_cnt,
  input logic [1:0] out_en
);
  a_r9_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe) |-> !scl_s);

  a_r9_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> !sda_oe);

  a_r6_host_ack_slot_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_TX_ACK |-> !sda_oe);

  a_r8_cfg_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(byte_cnt) || !$stable(out_en)) |-> !scl_s);

  a_r10_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_s |=> state == ST_RX);
endmodule

bind smb_reg_target smb_reg_target_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .start_s(start_s),
  .sda_oe(sda_oe_o), .state(link_state), .byte_cnt(byte_cnt_o),
  .out_en(out_en_o)
);

// File: tb/test_smb_reg_target.sv
module test_smb_reg_target;
  localparam int T = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [1:0] out_en;
  logic amp_sel;
  logic [2:0] amp_code;
  logic [3:0] rev_code, vendor_id;
  logic [7:0] byte_cnt;
  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] mdl [0:5];

  always #2 clk = ~clk;
  assign sda_line = sda_h & ~sda_oe;

  smb_reg_target i_smb_reg_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .out_en_o(out_en), .amp_sel_o(amp_sel),
    .amp_code_o(amp_code), .rev_code_o(rev_code), .vendor_id_o(vendor_id),
    .byte_cnt_o(byte_cnt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int i);
    return (i < 6) ? mdl[i] : 8'h00;
  endfunction

  task automatic wt(); repeat (T) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    sda_h = b; wt(); scl_h = 1'b1; wt(); scl_h = 1'b0; wt();
  endtask

  task automatic bit_in(output logic b);
    sda_h = 1'b1; wt(); scl_h = 1'b1;
    repeat (T/2) @(negedge clk);
    b = sda_line;
    repeat (T/2) @(negedge clk);
    scl_h = 1'b0; wt();
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wt(); scl_h = 1'b1; wt(); sda_h = 1'b0; wt(); scl_h = 1'b0; wt();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wt(); scl_h = 1'b1; wt(); sda_h = 1'b1; wt();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic rd_byte(input logic last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(last);
  endtask

  task automatic check_outputs(input string req);
    check({req, " out_en"},   32'(out_en),      32'({mdl[2][6], mdl[2][7]}));
    check({req, " amp_sel"},  32'(amp_sel),     32'(mdl[5][7]));
    check({req, " amp_code"}, 32'(amp_code),    32'(mdl[5][6:4]));
    check({req, " rev"},      32'(rev_code),    32'(mdl[3][7:4]));
    check({req, " vendor"},   32'(vendor_id),   32'(mdl[3][3:0]));
    check({req, " byte_cnt"}, 32'(byte_cnt),    32'(mdl[4]));
  endtask

  task automatic byte_write(input int idx, input logic [7:0] d);
    logic ack;
    bus_start();
    wr_byte(8'hD6, ack); check("R1 addr ack", 32'(ack), 1);
    wr_byte({1'b1, 7'(idx)}, ack);
    wr_byte(d, ack); check("R3 data ack", 32'(ack), 1);
    bus_stop();
    if (idx < 6) mdl[idx] = d;
  endtask

  task automatic byte_read(input int idx, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    wr_byte(8'hD6, ack);
    wr_byte({1'b1, 7'(idx)}, ack);
    bus_start();
    wr_byte(8'hD7, ack); check("R1 read addr ack", 32'(ack), 1);
    rd_byte(1'b1, d);
    bus_stop();
    check(req, 32'(d), 32'(exp_rd(idx)));
  endtask

  task automatic block_write(input int idx, input int cnt, input int n);
    logic ack;
    logic [7:0] b;
    bus_start();
    wr_byte(8'hD6, ack);
    wr_byte({1'b0, 7'(idx)}, ack);
    wr_byte(8'(cnt), ack); check("R5 count ack", 32'(ack), 1);
    for (int k = 0; k < n; k++) begin
      b = 8'($urandom);
      wr_byte(b, ack); check("R5 block data ack", 32'(ack), 1);
      if (k < cnt && idx + k < 6) mdl[idx + k] = b;
    end
    bus_stop();
  endtask

  task automatic block_read(input int idx, input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    wr_byte(8'hD6, ack);
    wr_byte({1'b0, 7'(idx)}, ack);
    bus_start();
    wr_byte(8'hD7, ack);
    rd_byte(n == 0, d);
    check("R6 count byte", 32'(d), 32'(mdl[4]));
    for (int k = 0; k < n; k++) begin
      rd_byte(k == n - 1, d);
      check((idx + k < 6) ? "R6 block data" : "R7 block data beyond", 32'(d), 32'(exp_rd(idx + k)));
    end
    bus_stop();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    void'($urandom(32'd1234));
    mdl[0] = 8'h00; mdl[1] = 8'h00; mdl[2] = 8'hC0;
    mdl[3] = 8'h08; mdl[4] = 8'h06; mdl[5] = 8'hD8;
    repeat (5) @(negedge clk);
    check("R9 sda released in reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 reset values at ports and by reads
    check_outputs("R2 R8 reset");
    for (int i = 0; i < 6; i++) byte_read(i, "R2 R4 reset read");

    // R1 foreign address: no ack, no change
    bus_start();
    wr_byte(8'hD4, ack); check("R1 foreign addr nack", 32'(ack), 0);
    wr_byte(8'h82, ack);
    wr_byte(8'h00, ack);
    bus_stop();
    check_outputs("R1 foreign addr no write");

    // R3 extra bytes after a single write are dropped
    bus_start();
    wr_byte(8'hD6, ack);
    wr_byte(8'h82, ack);
    wr_byte(8'h40, ack);
    wr_byte(8'h80, ack); check("R3 extra byte ack", 32'(ack), 1);
    bus_stop();
    mdl[2] = 8'h40;
    check_outputs("R3 R8 single write");

    // R10 START in the middle of a data byte
    bus_start();
    wr_byte(8'hD6, ack);
    wr_byte(8'h85, ack);
    bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
    bus_start();
    wr_byte(8'hD6, ack); check("R10 addr after restart", 32'(ack), 1);
    wr_byte(8'h80, ack);
    wr_byte(8'h5A, ack);
    bus_stop();
    mdl[0] = 8'h5A;
    check_outputs("R10 partial byte dropped");
    byte_read(5, "R10 reg5 intact");
    byte_read(0, "R10 write after restart");

    // R5 data beyond count, R7 run past last register
    block_write(0, 2, 4);
    byte_read(2, "R5 beyond count dropped");
    block_write(4, 4, 4);
    check_outputs("R7 R8 block write past end");
    byte_read(6, "R7 read beyond");
    byte_read(7, "R7 read beyond");
    block_read(0, 0);
    block_read(3, 5);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op, idx;
      op  = $urandom_range(0, 3);
      idx = $urandom_range(0, 7);
      case (op)
        0: byte_write(idx, 8'($urandom));
        1: byte_read(idx, (idx < 6) ? "R4 random read" : "R7 random read");
        2: block_write(idx, $urandom_range(0, 5), $urandom_range(0, 5));
        default: block_read(idx, $urandom_range(0, 5));
      endcase
      check_outputs("R8 random");
    end

    done = 1;
    finish_run();
  end
endmodule